// File: doc/BRIEF.md
# Frame-Buffer DRAM Controller with Selectable Byte-Strobe Scheme

This block drives a display-memory DRAM over a 16-bit data bus and a 10-bit multiplexed address bus. An internal arbiter hands it one read or one write at a time, using a request/ready handshake. Each request carries a 20-bit word address, which is split into a 10-bit row and a 10-bit column, plus two byte enables and write data. The controller sequences the row strobe, the two column/byte strobes and the write strobe. It returns read data with a one-cycle valid pulse.

A static mode input selects how byte writes reach the memory. In the split-CAS scheme, each byte lane has its own column strobe and a single write strobe covers both lanes. In the split-WE scheme, one pin is the shared column strobe and the other two pins become per-lane write enables. A free-running timer requests a CAS-before-RAS refresh at a programmable interval. A pending refresh wins over a queued access the next time the sequencer is idle.

Top module: `dram_ctrl`

## Requirements
- R1: During and directly after reset, `ras_no`, `ucas_no`, `lcas_no` and `we_no` are high, `md_oe_o` and `rvalid_o` are low, and `req_ready_o` is high.
- R2: In the cycle after a request is accepted, `ma_o` carries address bits [19:10] (row). In the two cycles after that, it carries bits [9:0] (column).
- R3: An access lasts six cycles counted from the accepting edge. RAS is low for three cycles, starting the cycle after acceptance. Column strobing is low for the second and third of those cycles. The next two cycles have every strobe high, and `req_ready_o` returns after them.
- R4: In split-CAS mode (`mode_two_we_i`=0), a write holds `we_no` low from the RAS fall through the last column cycle, so WE is already low when CAS falls. `ucas_no` falls only if enable bit 1 (upper byte, data [15:8]) is set, and `lcas_no` falls only if enable bit 0 (lower byte, data [7:0]) is set. `md_oe_o` is high and `md_o` equals the write data for the same three cycles.
- R5: In split-CAS mode, a read drops both `ucas_no` and `lcas_no` whatever the byte enables are. `we_no` stays high and `md_oe_o` stays low.
- R6: In split-WE mode (`mode_two_we_i`=1), `ucas_no` is the common column strobe for reads, writes and refresh. `lcas_no` is the lower-byte write enable and `we_no` is the upper-byte write enable. Each is low from the RAS fall through the last column cycle, only for a write with its enable bit set, and both stay high during refresh.
- R7: Read data is sampled from `md_i` at the end of the last column cycle. It appears on `rdata_o` with `rvalid_o` high for exactly the one cycle that follows; writes produce no pulse.
- R8: A refresh becomes pending every `REFRESH_INTERVAL` cycles. It runs as CAS-before-RAS: column strobe(s) fall one cycle before RAS, both stay low for two further cycles with WE high, and then two precharge cycles follow. With no traffic, refresh starts are exactly `REFRESH_INTERVAL` cycles apart.
- R9: While a refresh is pending, `req_ready_o` is low and the refresh starts before any new access. Under a continuous request stream, refreshes still occur, each within a few cycles of its nominal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_two_we_i | input | 1 | 0: split-CAS byte strobes, 1: split-WE byte strobes; change only while idle |
| req_i | input | 1 | Access request from the arbiter |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_be_i | input | 2 | Byte enables for writes, bit 1 upper lane |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Request accepted on a clock edge where this and req_i are high |
| rdata_o | output | 16 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o |
| ma_o | output | 10 | Multiplexed DRAM address |
| md_o | output | 16 | DRAM write data |
| md_oe_o | output | 1 | Output enable for md_o |
| md_i | input | 16 | DRAM read data |
| ras_no | output | 1 | Row strobe, active low |
| ucas_no | output | 1 | Upper column strobe, or common CAS in split-WE mode |
| lcas_no | output | 1 | Lower column strobe, or lower write enable in split-WE mode |
| we_no | output | 1 | Write strobe, or upper write enable in split-WE mode |

## Verification
The hardest situation to reach is a refresh that falls due while an access is in flight. In that case, priority must hold back the arbiter's next request instead of letting traffic starve refresh. The bench holds `req_i` high for several refresh intervals so that every idle cycle competes with a request. It then checks the spacing of successive CAS-before-RAS starts against the interval, and it checks that `req_ready_o` is low at each start. Read capture timing is exposed by driving different `md_i` values on the two column cycles.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL1,
    ST_COL2,
    ST_RF_CAS,
    ST_RF_RAS1,
    ST_RF_RAS2,
    ST_PRE1,
    ST_PRE2
  } seq_state_e;

  // active-high phase flags from sequencer to pin mapper
  typedef struct packed {
    logic ras;
    logic cas;
    logic wr;
    logic rf;
  } phase_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pending_o
);
  localparam int unsigned CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= LOAD;
      pending_q <= 1'b0;
    end else begin
      if (ack_i) pending_q <= 1'b0;
      if (cnt_q == '0) begin
        cnt_q     <= LOAD;
        pending_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pending_o = pending_q;

  // R8
  rf_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_q) |-> $past(cnt_q == '0));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned MA_W   = 10,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned ADDR_W = 2 * MA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rf_pending_i,
  input  logic [DATA_W-1:0] md_i,
  output logic              ready_o,
  output logic              rf_ack_o,
  output phase_t            ph_o,
  output logic [BE_W-1:0]   be_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [DATA_W-1:0] md_o,
  output logic              md_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;
  logic              accept, in_access;

  assign ready_o  = (state_q == ST_IDLE) && !rf_pending_i;
  assign rf_ack_o = (state_q == ST_IDLE) && rf_pending_i;
  assign accept   = ready_o && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rf_pending_i) state_d = ST_RF_CAS;
        else if (req_i)   state_d = ST_ROW;
      end
      ST_ROW:     state_d = ST_COL1;
      ST_COL1:    state_d = ST_COL2;
      ST_COL2:    state_d = ST_PRE1;
      ST_RF_CAS:  state_d = ST_RF_RAS1;
      ST_RF_RAS1: state_d = ST_RF_RAS2;
      ST_RF_RAS2: state_d = ST_PRE1;
      ST_PRE1:    state_d = ST_PRE2;
      ST_PRE2:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      be_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= 1'b0;
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        be_q    <= be_i;
        wdata_q <= wdata_i;
      end
      // sample on the last column cycle
      if (state_q == ST_COL2 && !we_q) begin
        rdata_q  <= md_i;
        rvalid_q <= 1'b1;
      end
    end
  end

  assign in_access = (state_q == ST_ROW) || (state_q == ST_COL1) || (state_q == ST_COL2);

  always_comb begin
    ph_o.ras = in_access || (state_q == ST_RF_RAS1) || (state_q == ST_RF_RAS2);
    ph_o.cas = (state_q == ST_COL1) || (state_q == ST_COL2) || (state_q == ST_RF_CAS)
            || (state_q == ST_RF_RAS1) || (state_q == ST_RF_RAS2);
    ph_o.wr  = in_access && we_q;
    ph_o.rf  = (state_q == ST_RF_CAS) || (state_q == ST_RF_RAS1) || (state_q == ST_RF_RAS2);
  end

  always_comb begin
    ma_o = '0;
    if (state_q == ST_ROW) ma_o = addr_q[ADDR_W-1:MA_W];
    else if (state_q == ST_COL1 || state_q == ST_COL2) ma_o = addr_q[MA_W-1:0];
  end

  assign be_o     = be_q;
  assign md_o     = wdata_q;
  assign md_oe_o  = ph_o.wr;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R9
  rf_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rf_pending_i) |=> (state_q == ST_RF_CAS));

  // R7
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/dram_strobe_map.sv
module dram_strobe_map
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned BE_W = 2
) (
  input  logic            mode_two_we_i,
  input  phase_t          ph_i,
  input  logic [BE_W-1:0] be_i,
  output logic            ras_no,
  output logic            ucas_no,
  output logic            lcas_no,
  output logic            we_no
);
  logic up_en, lo_en;

  assign up_en  = be_i[BE_W-1];
  assign lo_en  = be_i[0];
  assign ras_no = ~ph_i.ras;

  always_comb begin
    if (mode_two_we_i) begin
      ucas_no = ~ph_i.cas;
      lcas_no = ~(ph_i.wr && lo_en);
      we_no   = ~(ph_i.wr && up_en);
    end else begin
      // reads and refresh strobe both lanes
      ucas_no = ~(ph_i.cas && (!ph_i.wr || up_en));
      lcas_no = ~(ph_i.cas && (!ph_i.wr || lo_en));
      we_no   = ~ph_i.wr;
    end
  end

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned MA_W             = 10,
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned REFRESH_INTERVAL = 780,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned ADDR_W = 2 * MA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_two_we_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [DATA_W-1:0] md_o,
  output logic              md_oe_o,
  input  logic [DATA_W-1:0] md_i,
  output logic              ras_no,
  output logic              ucas_no,
  output logic              lcas_no,
  output logic              we_no
);
  logic            rf_pending, rf_ack;
  phase_t          ph;
  logic [BE_W-1:0] be_q;

  dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (rf_ack),
    .pending_o (rf_pending)
  );

  dram_seq #(.MA_W(MA_W), .DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (req_we_i),
    .addr_i       (req_addr_i),
    .be_i         (req_be_i),
    .wdata_i      (req_wdata_i),
    .rf_pending_i (rf_pending),
    .md_i         (md_i),
    .ready_o      (req_ready_o),
    .rf_ack_o     (rf_ack),
    .ph_o         (ph),
    .be_o         (be_q),
    .ma_o         (ma_o),
    .md_o         (md_o),
    .md_oe_o      (md_oe_o),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o)
  );

  dram_strobe_map #(.BE_W(BE_W)) u_map (
    .mode_two_we_i (mode_two_we_i),
    .ph_i          (ph),
    .be_i          (be_q),
    .ras_no        (ras_no),
    .ucas_no       (ucas_no),
    .lcas_no       (lcas_no),
    .we_no         (we_no)
  );

  // R3
  ras_before_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_two_we_i && !ph.rf && $fell(ucas_no)) |-> $past(!ras_no));

  // R8
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph.rf && $fell(ras_no)) |-> (!ucas_no && $past(!ucas_no) && we_no));

  // R6
  byte_we_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_two_we_i && (!we_no || !lcas_no)) |-> !ras_no);

endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int IVL = 60;

  typedef struct packed {
    logic        mode;
    logic        wr;
    logic [1:0]  be;
    logic [19:0] addr;
    logic [15:0] data;
    logic [2:0]  row_exp;  // {ucas_no, lcas_no, we_no}
    logic [2:0]  col_exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 2'b11, 20'h12345, 16'hA5C3, 3'b110, 3'b000},
    '{1'b0, 1'b1, 2'b10, 20'hFFC01, 16'h1234, 3'b110, 3'b010},
    '{1'b0, 1'b1, 2'b01, 20'h003FF, 16'hBEEF, 3'b110, 3'b100},
    '{1'b0, 1'b0, 2'b00, 20'h8A5A5, 16'h0F0F, 3'b111, 3'b001},
    '{1'b1, 1'b1, 2'b11, 20'h55AAA, 16'h6789, 3'b100, 3'b000},
    '{1'b1, 1'b1, 2'b01, 20'h00001, 16'hC001, 3'b101, 3'b001},
    '{1'b1, 1'b1, 2'b10, 20'hFFFFF, 16'h7E7E, 3'b110, 3'b010},
    '{1'b1, 1'b0, 2'b11, 20'h3C3C3, 16'h9999, 3'b111, 3'b011}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mode_two_we_i = 1'b0, req_i = 1'b0, req_we_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0, md_i = '0;
  logic        req_ready_o, rvalid_o, md_oe_o, ras_no, ucas_no, lcas_no, we_no;
  logic [15:0] rdata_o, md_o;
  logic [9:0]  ma_o;

  int nchk = 0, nfail = 0, cyc = 0;

  dram_ctrl #(.REFRESH_INTERVAL(IVL)) uut (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [2:0] pins();
    return {ucas_no, lcas_no, we_no};
  endfunction

  task automatic do_access(input vec_t v);
    string tg;
    tg = v.mode ? "R6" : (v.wr ? "R4" : "R5");
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    mode_two_we_i = v.mode; req_i = 1'b1; req_we_i = v.wr;
    req_be_i = v.be; req_addr_i = v.addr; req_wdata_i = v.data;
    @(negedge clk_i);  // row cycle
    req_i = 1'b0;
    chk("R2 row", ma_o, v.addr[19:10]);
    chk("R3 ras row", ras_no, 1'b0);
    chk(tg, pins(), v.row_exp);
    chk(tg, md_oe_o, v.wr);
    if (v.wr) chk("R4 md_o", md_o, v.data);
    @(negedge clk_i);  // col 1
    chk("R2 col", ma_o, v.addr[9:0]);
    chk("R3 ras col1", ras_no, 1'b0);
    chk(tg, pins(), v.col_exp);
    md_i = 16'hDEAD;
    @(negedge clk_i);  // col 2
    chk("R3 ras col2", ras_no, 1'b0);
    chk(tg, pins(), v.col_exp);
    md_i = v.data ^ 16'h5A5A;
    @(negedge clk_i);  // precharge 1
    md_i = 16'h0000;
    chk("R3 pre1", {ras_no, pins()}, 4'b1111);
    chk("R7 rvalid", rvalid_o, !v.wr);
    if (!v.wr) chk("R7 rdata", rdata_o, v.data ^ 16'h5A5A);
    @(negedge clk_i);  // precharge 2
    chk("R3 pre2", {ras_no, pins()}, 4'b1111);
    chk("R7 pulse", rvalid_o, 1'b0);
    chk("R3 busy", req_ready_o, 1'b0);
  endtask

  task automatic find_cbr(output int t);
    logic pu;
    t = -1;
    pu = ucas_no;
    for (int k = 0; k < 300 && t < 0; k++) begin
      @(negedge clk_i);
      if (!ucas_no && ras_no && pu) t = cyc;
      pu = ucas_no;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog R1..: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int t1, t2, gaps_ok, nstart, prev;
    repeat (3) @(negedge clk_i);
    chk("R1 strobes", {ras_no, ucas_no, lcas_no, we_no}, 4'b1111);
    chk("R1 rvalid", rvalid_o, 1'b0);
    chk("R1 oe", md_oe_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after", {ras_no, ucas_no, lcas_no, we_no}, 4'b1111);
    chk("R1 ready", req_ready_o, 1'b1);

    foreach (VEC[i]) do_access(VEC[i]);

    // idle refresh in split-CAS mode
    mode_two_we_i = 1'b0;
    find_cbr(t1);
    chk("R8 found", t1 >= 0, 1'b1);
    chk("R8 cbr start", {ras_no, lcas_no, we_no}, 3'b101);
    chk("R9 ready low", req_ready_o, 1'b0);
    @(negedge clk_i);
    chk("R8 cbr ras1", {ras_no, ucas_no, lcas_no, we_no}, 4'b0001);
    @(negedge clk_i);
    chk("R8 cbr ras2", {ras_no, ucas_no, lcas_no, we_no}, 4'b0001);
    @(negedge clk_i);
    chk("R8 pre1", {ras_no, ucas_no, lcas_no, we_no}, 4'b1111);
    @(negedge clk_i);
    chk("R8 pre2", {ras_no, ucas_no, lcas_no, we_no}, 4'b1111);
    find_cbr(t2);
    chk("R8 interval", t2 - t1, IVL);

    // refresh in split-WE mode
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    mode_two_we_i = 1'b1;
    find_cbr(t1);
    chk("R6 rf pins", {ras_no, ucas_no, lcas_no, we_no}, 4'b1011);
    @(negedge clk_i);
    chk("R6 rf ras", {ras_no, ucas_no, lcas_no, we_no}, 4'b0011);

    // continuous traffic: refresh must not starve (R9)
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    mode_two_we_i = 1'b0;
    req_i = 1'b1; req_we_i = 1'b0; req_be_i = 2'b11; req_addr_i = 20'h0ABCD;
    nstart = 0; gaps_ok = 1; prev = -1;
    begin
      logic pu;
      pu = ucas_no;
      for (int k = 0; k < 4 * IVL; k++) begin
        @(negedge clk_i);
        if (!ucas_no && ras_no && pu) begin
          nstart++;
          chk("R9 ready at rf", req_ready_o, 1'b0);
          if (prev >= 0 && ((cyc - prev) > IVL + 8 || (cyc - prev) < IVL - 8)) gaps_ok = 0;
          prev = cyc;
        end
        pu = ucas_no;
      end
    end
    req_i = 1'b0;
    chk("R9 rf count", nstart >= 3, 1'b1);
    chk("R9 rf spacing", gaps_ok, 1);

    repeat (10) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule